// File: doc/BRIEF.md
# DDR Self-Refresh Entry/Exit Sequencer

This block sits between a memory controller core and the command pins of a DDR SDRAM. It places the device into self refresh when the controller asks, and later runs the full exit sequence before it hands the bus back. The controller holds `sr_req` high to ask for entry. The block waits until the controller reports that every bank is precharged and idle. It then issues one refresh command with CKE low and pulses `sr_ack`. While the device is in self refresh, CKE stays low and the command pins are parked at NOP.

An exit is requested with `exit_req`. That request is acknowledged only while the device sits in self refresh. CKE goes high once the clock is reported stable, or once a settle count runs out if that comes first. The block then drives NOPs for the exit-recovery time and loads the mode register with the DLL-reset bit set. After that it drives NOPs for the DLL lock time. Only then does `ready` rise again. No DLL-disable command is sent on entry, because the device turns its DLL off and on by itself.

Top module: `ddr_sr_seq`

## Requirements
- R1: After reset, CKE is high, the command pins carry NOP ({cs_n,ras_n,cas_n,we_n} = 0111), `ready` is high, and both acknowledges are low.
- R2: When `sr_req` and `banks_idle` are both high at a clock edge, the next cycle carries exactly one refresh command (0001) with CKE low, and `sr_ack` is high in that same cycle.
- R3: While `sr_req` is high and `banks_idle` is low, no command other than NOP is issued, CKE stays high, `sr_ack` stays low and `ready` is low.
- R4: In self refresh, CKE stays low and the command pins carry NOP. `exit_ack` is high only while `exit_req` is high in self refresh. An `exit_req` raised in any other state leaves `exit_ack` low.
- R5: After the exit acknowledge, CKE stays low for min(s, T_SETTLE) cycles, where s is the cycle in which `clk_stable` is first seen high (counting from 1).
- R6: From the first cycle with CKE high, exactly T_XSNR NOP cycles pass before the mode-register load.
- R7: The mode-register load is a single cycle with command 0000, `ba` = 0 and `addr` = `mode_cfg` with bit DLL_BIT set. It is the only command besides the refresh in a full entry/exit cycle.
- R8: Exactly T_DLL NOP cycles follow the mode-register load. `ready` rises in the cycle after the last of them.
- R9: `ready` stays low from the cycle `sr_req` is raised until the count in R8 expires.
- R10: While `ready` is high, CKE is high and the command pins carry NOP.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sr_req | input | 1 | Level request to enter self refresh |
| sr_ack | output | 1 | High in the cycle the entry command is issued |
| exit_req | input | 1 | Request to leave self refresh |
| exit_ack | output | 1 | Acknowledge of an exit request, only while in self refresh |
| banks_idle | input | 1 | All banks are precharged and idle |
| clk_stable | input | 1 | Memory clock has settled |
| mode_cfg | input | AW | Mode-register value to load during exit |
| cke | output | 1 | Clock enable to the DRAM |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| addr | output | AW | Address pins (mode value during the load) |
| ba | output | BAW | Bank address, zero for the mode-register load |
| ready | output | 1 | Normal commands may be issued |

## Verification
The bench counts the exact number of cycles between the CKE rise, the mode-register load and the rise of `ready`. It does this for several mode values and clock-settle timings. A design off by one in either wait would issue the load too early, or release a read before the DLL has locked. Some vectors hold `banks_idle` low while the request is pending. A design that ignored it would enter self refresh with rows still open. Other vectors report `clk_stable` before the settle count expires, at its last cycle, and never. A design that got this wrong would raise CKE on an unsettled clock or stall longer than needed. An exit request is also driven while the block is idle and during the DLL wait. A design that acknowledged either one would drop CKE or restart the sequence by mistake.

// File: rtl/ddr_sr_seq.sv
module ddr_sr_seq #(
  parameter int AW       = 13,
  parameter int BAW      = 2,
  parameter int DLL_BIT  = 8,
  parameter int T_SETTLE = 16,
  parameter int T_XSNR   = 10,
  parameter int T_DLL    = 200
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           sr_req,
  output logic           sr_ack,
  input  logic           exit_req,
  output logic           exit_ack,
  input  logic           banks_idle,
  input  logic           clk_stable,
  input  logic [AW-1:0]  mode_cfg,
  output logic           cke,
  output logic           cs_n,
  output logic           ras_n,
  output logic           cas_n,
  output logic           we_n,
  output logic [AW-1:0]  addr,
  output logic [BAW-1:0] ba,
  output logic           ready
);

  localparam int CMAX_A = (T_XSNR > T_SETTLE) ? T_XSNR : T_SETTLE;
  localparam int CMAX   = (T_DLL > CMAX_A) ? T_DLL : CMAX_A;
  localparam int CW     = $clog2(CMAX + 1);

  localparam logic [3:0] CMD_NOP = 4'b0111;
  localparam logic [3:0] CMD_REF = 4'b0001;
  localparam logic [3:0] CMD_LMR = 4'b0000;

  typedef enum logic [2:0] {
    S_IDLE, S_ENTER, S_IN_SR, S_CLK_WAIT, S_XSNR, S_DLL_RST, S_DLL_WAIT, S_READY
  } st_t;

  st_t           st, nx;
  logic [CW-1:0] cnt, cnt_nx;
  logic [3:0]    cmd;
  logic          cnt_done;
  logic          home;

  assign cnt_done = (cnt == '0);
  assign home     = (st == S_IDLE) || (st == S_READY);

  always_comb begin
    nx = st;
    case (st)
      S_IDLE, S_READY: if (sr_req && banks_idle) nx = S_ENTER;
      S_ENTER:         nx = S_IN_SR;
      S_IN_SR:         if (exit_req) nx = S_CLK_WAIT;
      S_CLK_WAIT:      if (clk_stable || cnt_done) nx = S_XSNR;
      S_XSNR:          if (cnt_done) nx = S_DLL_RST;
      S_DLL_RST:       nx = S_DLL_WAIT;
      S_DLL_WAIT:      if (cnt_done) nx = S_READY;
      default:         nx = S_IDLE;
    endcase
  end

  always_comb begin
    cnt_nx = cnt_done ? cnt : cnt - 1'b1;
    if (nx != st) begin
      case (nx)
        S_CLK_WAIT: cnt_nx = CW'(T_SETTLE - 1);
        S_XSNR:     cnt_nx = CW'(T_XSNR - 1);
        S_DLL_WAIT: cnt_nx = CW'(T_DLL - 1);
        default:    cnt_nx = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= S_IDLE;
      cnt <= '0;
    end else begin
      st  <= nx;
      cnt <= cnt_nx;
    end
  end

  assign cmd = (st == S_ENTER)   ? CMD_REF :
               (st == S_DLL_RST) ? CMD_LMR : CMD_NOP;
  assign {cs_n, ras_n, cas_n, we_n} = cmd;
  assign cke      = !(st == S_ENTER || st == S_IN_SR || st == S_CLK_WAIT);
  assign addr     = (st == S_DLL_RST) ? (mode_cfg | (AW'(1) << DLL_BIT)) : '0;
  assign ba       = '0;
  assign sr_ack   = (st == S_ENTER);
  assign exit_ack = (st == S_IN_SR) && exit_req;
  assign ready    = home && !sr_req;

  p_ref_on_cke_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cke) |-> (cmd == CMD_REF && sr_ack));

  p_ack_needs_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sr_ack |-> ($past(banks_idle) && $past(sr_req)));

  p_parked_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke && !sr_ack) |-> (cmd == CMD_NOP));

  p_exit_ack_low_cke_r4: assert property (@(posedge clk) disable iff (!rst_n)
    exit_ack |-> (!cke && !sr_ack));

  p_rise_nop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cke) |-> (cmd == CMD_NOP));

  p_lmr_fields_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_LMR) |-> (cke && addr[DLL_BIT] && ba == '0 && $past(cmd) == CMD_NOP && $past(cke)));

  p_no_ready_after_lmr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_LMR) |=> !ready);

  p_ready_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (cke && cmd == CMD_NOP));

endmodule

// File: tb/tb_ddr_sr_seq.sv
module tb_ddr_sr_seq;
  localparam int AW = 13, BAW = 2, DLL_BIT = 8;
  localparam int T_SETTLE = 16, T_XSNR = 10, T_DLL = 200;
  localparam int NROW = 5;
  localparam int LIMIT = 1000;

  localparam int          ROW_IDLE [NROW] = '{0, 3, 1, 0, 2};
  localparam int          ROW_STAB [NROW] = '{1, 5, 40, 16, 15};
  localparam logic [12:0] ROW_MODE [NROW] = '{13'h0062, 13'h0000, 13'h0163, 13'h1FFF, 13'h0031};

  logic clk = 1'b0, rst_n = 1'b0;
  logic sr_req = 1'b0, exit_req = 1'b0, banks_idle = 1'b0, clk_stable = 1'b0;
  logic [AW-1:0] mode_cfg = '0;
  logic sr_ack, exit_ack, cke, cs_n, ras_n, cas_n, we_n, ready;
  logic [AW-1:0] addr;
  logic [BAW-1:0] ba;
  wire [3:0] bcmd = {cs_n, ras_n, cas_n, we_n};

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  ddr_sr_seq #(.AW(AW), .BAW(BAW), .DLL_BIT(DLL_BIT), .T_SETTLE(T_SETTLE),
               .T_XSNR(T_XSNR), .T_DLL(T_DLL)) dut (
    .clk(clk), .rst_n(rst_n), .sr_req(sr_req), .sr_ack(sr_ack),
    .exit_req(exit_req), .exit_ack(exit_ack), .banks_idle(banks_idle),
    .clk_stable(clk_stable), .mode_cfg(mode_cfg), .cke(cke), .cs_n(cs_n),
    .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .addr(addr), .ba(ba), .ready(ready));

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 150000);
      summary();
      $finish;
    end
  end

  task automatic run_row(input int r);
    int low, nx, nd;
    int exp_low;
    logic [AW-1:0] exp_addr;
    exp_low  = (ROW_STAB[r] < T_SETTLE) ? ROW_STAB[r] : T_SETTLE;
    exp_addr = ROW_MODE[r] | (AW'(1) << DLL_BIT);
    mode_cfg   = ROW_MODE[r];
    clk_stable = 1'b0;
    sr_req     = 1'b1;
    banks_idle = (ROW_IDLE[r] == 0);
    #1;
    chk(ready == 1'b0, "R9", "ready on request", ready, 0);
    for (int i = 0; i < ROW_IDLE[r]; i++) begin
      @(negedge clk);
      chk(cke && bcmd == 4'b0111 && !sr_ack && !ready, "R3", "held while banks busy",
          {cke, bcmd, sr_ack, ready}, {1'b1, 4'b0111, 2'b00});
      if (i == ROW_IDLE[r] - 1) banks_idle = 1'b1;
    end
    @(negedge clk);
    chk(!cke && bcmd == 4'b0001 && sr_ack, "R2", "entry command",
        {cke, bcmd, sr_ack}, {1'b0, 4'b0001, 1'b1});
    sr_req = 1'b0;
    banks_idle = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(!cke && bcmd == 4'b0111 && !ready && !exit_ack, "R4", "parked in self refresh",
          {cke, bcmd, ready, exit_ack}, {1'b0, 4'b0111, 2'b00});
    end
    exit_req = 1'b1;
    #1;
    chk(exit_ack == 1'b1, "R4", "exit acknowledged", exit_ack, 1);
    @(negedge clk);
    exit_req = 1'b0;
    low = 0;
    while (!cke && low < LIMIT) begin
      low++;
      if (bcmd != 4'b0111) chk(1'b0, "R4", "non-NOP while CKE low", bcmd, 4'b0111);
      if (low == ROW_STAB[r]) clk_stable = 1'b1;
      @(negedge clk);
    end
    chk(low == exp_low, "R5", "CKE low cycles after exit", low, exp_low);
    nx = 0;
    while (cke && bcmd == 4'b0111 && nx < LIMIT) begin
      nx++;
      chk(!ready, "R9", "ready during recovery", ready, 0);
      @(negedge clk);
    end
    chk(nx == T_XSNR, "R6", "NOPs before mode load", nx, T_XSNR);
    chk(bcmd == 4'b0000 && addr == exp_addr && ba == '0 && cke, "R7", "mode load fields",
        {bcmd, addr}, {4'b0000, exp_addr});
    @(negedge clk);
    nd = 0;
    while (!ready && nd < LIMIT) begin
      nd++;
      if (bcmd != 4'b0111 || !cke) chk(1'b0, "R8", "non-NOP during DLL wait", {cke, bcmd}, {1'b1, 4'b0111});
      if (nd == 1) begin
        exit_req = 1'b1;
        #1;
        chk(exit_ack == 1'b0, "R4", "exit ignored in DLL wait", exit_ack, 0);
      end
      if (nd == 2) exit_req = 1'b0;
      @(negedge clk);
    end
    chk(nd == T_DLL, "R8", "NOPs after mode load", nd, T_DLL);
    chk(cke && bcmd == 4'b0111, "R10", "quiet when ready", {cke, bcmd}, {1'b1, 4'b0111});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cke && bcmd == 4'b0111 && ready && !sr_ack && !exit_ack, "R1", "reset state",
        {cke, bcmd, ready, sr_ack, exit_ack}, {1'b1, 4'b0111, 1'b1, 2'b00});
    exit_req = 1'b1;
    #1;
    chk(exit_ack == 1'b0, "R4", "exit ignored when idle", exit_ack, 0);
    @(negedge clk);
    exit_req = 1'b0;
    chk(cke && ready, "R10", "idle after stray exit", {cke, ready}, 2'b11);
    for (int r = 0; r < NROW; r++) begin
      run_row(r);
      repeat (2) @(negedge clk);
    end
    sr_req = 1'b1;
    banks_idle = 1'b0;
    repeat (4) @(negedge clk);
    chk(cke && !sr_ack && !ready, "R3", "long busy hold", {cke, sr_ack, ready}, 3'b100);
    sr_req = 1'b0;
    @(negedge clk);
    chk(cke && ready && bcmd == 4'b0111, "R10", "withdrawn request", {cke, ready, bcmd}, {2'b11, 4'b0111});
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cke && ready && bcmd == 4'b0111, "R1", "second reset", {cke, ready, bcmd}, {2'b11, 4'b0111});
    done = 1'b1;
    summary();
    $finish;
  end
endmodule